// File: doc/BRIEF.md
# FFT Result Readout Buffer

This block sits at the output side of an FFT engine that runs in a different clock domain. The engine presents a whole result frame at once on a wide parallel bus: 32 complex points, each a real and an imaginary 16-bit word, 64 words in all. It raises a request line to announce the frame. The buffer answers with a four-phase push handshake. It synchronizes the request into its own clock, raises its acknowledge, and loads the whole bus into an internal page on the clock edge where the acknowledge rises. When the request falls, it lowers the acknowledge.

A host reads the stored frame one word at a time. A 5-bit point select and a 1-bit part select pick a word, which appears registered on a single 16-bit output. The words are in 8.8 fixed point, with 8 integer bits above 8 fractional bits, and the block passes them through unchanged. A frame-ready flag shows that the page holds a complete frame. A global enable freezes the whole block when it is low.

Top module: `fft_result_reader`

## Requirements
- R1: With enable high, a request raised while the acknowledge is low makes the acknowledge rise on the 4th rising clock edge after the request goes high: two synchronizer stages, one load cycle, then the acknowledge.
- R2: On the edge where the acknowledge rises, all 64 bus words are stored. Word k of the page is taken from bus bits [16k+15:16k].
- R3: After the request falls, the acknowledge falls on the 3rd rising clock edge, and only while the acknowledge is already high.
- R4: While the acknowledge is high, the request staying high or the bus changing causes no new capture. A new transfer starts only after the acknowledge has returned low and the request is seen high again.
- R5: The read word is page word 2*point + part. Part 0 selects the real word and part 1 selects the imaginary word of the point.
- R6: The read word follows a change of the selects on the next rising edge. Before the first capture every read word is zero.
- R7: While enable is low, the acknowledge, the frame-ready flag, the stored page and the read word all hold their values.
- R8: Frame-ready goes low on the edge where a new request is first seen after synchronization. It goes high on the capture edge and stays high until the next request.
- R9: After reset the acknowledge, the frame-ready flag and the read word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock of the buffer |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable; when low the block is frozen |
| req_i | input | 1 | Request from the FFT engine, asynchronous |
| frame_i | input | 1024 | 64 words of 16 bits; word k in bits [16k+15:16k] |
| pt_sel_i | input | 5 | Point to read |
| part_sel_i | input | 1 | 0 = real word, 1 = imaginary word |
| ack_o | output | 1 | Acknowledge to the FFT engine |
| rd_word_o | output | 16 | Selected 8.8 word, registered |
| frame_ready_o | output | 1 | A complete frame is held |

## Verification
The hardest case to reach from the ports is a request that is still high, or raised again, while the acknowledge from the previous transfer is high. In that window a careless design would capture again. The bench holds the request high well past the acknowledge and swaps the bus contents during that time. It then drops the request and reads back words, to show the page still holds the old frame. Only after that does it run a fresh transfer. A second hard case is a request that arrives while enable is low. The bench keeps enable low for several cycles with the request raised, then releases enable and counts the two edges to the acknowledge.

// File: rtl/fft_rdbuf_pkg.sv
package fft_rdbuf_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_LOAD = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_t;
endpackage

// File: rtl/rdbuf_req_sync.sv
module rdbuf_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rdbuf_hs_fsm.sv
module rdbuf_hs_fsm
  import fft_rdbuf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      req_s_i,
  output logic      ack_o,
  output logic      cap_o,
  output logic      ready_o,
  output hs_state_t state_o
);
  hs_state_t state_q, state_d;
  logic      ready_q, ready_d;

  always_comb begin
    state_d = state_q;
    ready_d = ready_q;
    cap_o   = 1'b0;
    if (en_i) begin
      unique case (state_q)
        HS_IDLE: if (req_s_i) begin
          state_d = HS_LOAD;
          ready_d = 1'b0;
        end
        HS_LOAD: begin
          state_d = HS_ACK;
          ready_d = 1'b1;
          cap_o   = 1'b1;
        end
        HS_ACK: if (!req_s_i) state_d = HS_IDLE;
        default: state_d = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= ready_d;
    end
  end

  assign ack_o   = (state_q == HS_ACK);
  assign ready_o = ready_q;
  assign state_o = state_q;
endmodule

// File: rtl/rdbuf_frame_store.sv
module rdbuf_frame_store #(
  parameter int NUM_PTS = 32,
  parameter int WORD_W  = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        cap_i,
  input  logic [2*NUM_PTS*WORD_W-1:0] frame_i,
  input  logic [$clog2(NUM_PTS)-1:0]  pt_sel_i,
  input  logic                        part_sel_i,
  output logic [WORD_W-1:0]           rd_word_o
);
  localparam int WORDS = 2 * NUM_PTS;
  localparam int IDX_W = $clog2(NUM_PTS) + 1;

  logic [WORD_W-1:0] page_q [WORDS];
  logic [WORD_W-1:0] rd_q, rd_d;
  logic [IDX_W-1:0]  idx;

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            page_q[k] <= '0;
      else if (en_i && cap_i) page_q[k] <= frame_i[k*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    idx  = {pt_sel_i, part_sel_i};
    rd_d = page_q[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (en_i) rd_q <= rd_d;
  end

  assign rd_word_o = rd_q;
endmodule

// File: rtl/fft_result_reader.sv
module fft_result_reader
  import fft_rdbuf_pkg::*;
#(
  parameter int NUM_PTS     = 32,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        req_i,
  input  logic [2*NUM_PTS*WORD_W-1:0] frame_i,
  input  logic [$clog2(NUM_PTS)-1:0]  pt_sel_i,
  input  logic                        part_sel_i,
  output logic                        ack_o,
  output logic [WORD_W-1:0]           rd_word_o,
  output logic                        frame_ready_o
);
  logic      req_s;
  logic      cap;
  hs_state_t hs_state;

  rdbuf_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(req_i),
    .sync_o (req_s)
  );

  rdbuf_hs_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .req_s_i(req_s),
    .ack_o  (ack_o),
    .cap_o  (cap),
    .ready_o(frame_ready_o),
    .state_o(hs_state)
  );

  rdbuf_frame_store #(.NUM_PTS(NUM_PTS), .WORD_W(WORD_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .cap_i     (cap),
    .frame_i   (frame_i),
    .pt_sel_i  (pt_sel_i),
    .part_sel_i(part_sel_i),
    .rd_word_o (rd_word_o)
  );
endmodule

// File: rtl/fft_result_reader_chk.sv
module fft_result_reader_chk
  import fft_rdbuf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              req_s,
  input logic              ack_o,
  input logic              frame_ready_o,
  input logic [WORD_W-1:0] rd_word_o,
  input hs_state_t         hs_state
);
  AST_ACK_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(hs_state == HS_LOAD)); // R1

  AST_ACK_FALL_ON_REQ_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> (!$past(req_s) && $past(en_i))); // R3

  AST_NO_NEW_XFER_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && req_s) |=> (ack_o && hs_state == HS_ACK)); // R4

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(ack_o) && $stable(frame_ready_o) && $stable(rd_word_o))); // R7

  AST_READY_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> frame_ready_o); // R8
endmodule

bind fft_result_reader fft_result_reader_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .req_s        (req_s),
  .ack_o        (ack_o),
  .frame_ready_o(frame_ready_o),
  .rd_word_o    (rd_word_o),
  .hs_state     (hs_state)
);

// File: tb/fft_result_reader_bench.sv
module fft_result_reader_bench;
  localparam int NP = 32;
  localparam int WW = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              en_i;
  logic              req_i;
  logic [2*NP*WW-1:0] frame_i;
  logic [4:0]        pt_sel_i;
  logic              part_sel_i;
  logic              ack_o;
  logic [WW-1:0]     rd_word_o;
  logic              frame_ready_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  fft_result_reader u_fft_result_reader (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .req_i(req_i),
    .frame_i(frame_i), .pt_sel_i(pt_sel_i), .part_sel_i(part_sel_i),
    .ack_o(ack_o), .rd_word_o(rd_word_o), .frame_ready_o(frame_ready_o)
  );

  function automatic logic [WW-1:0] pat(int s, int k);
    return 16'((s * 997 + k * 73 + (k << 9) + s) & 16'hFFFF);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic load_bus(int s);
    for (int k = 0; k < 2*NP; k++) frame_i[k*WW +: WW] = pat(s, k);
  endtask

  task automatic read_word(int pt, int part, int s, string req);
    pt_sel_i = 5'(pt);
    part_sel_i = part[0];
    step(1);
    chk(req, 32'(rd_word_o), 32'(pat(s, 2*pt + part)));
  endtask

  task automatic t_reset;
    chk("R9 ack", 32'(ack_o), 0);
    chk("R9 ready", 32'(frame_ready_o), 0);
    chk("R9 read", 32'(rd_word_o), 0);
    pt_sel_i = 5'd7; part_sel_i = 1'b1;
    step(1);
    chk("R6 zero before capture", 32'(rd_word_o), 0);
  endtask

  task automatic t_transfer(int s, logic ready_before);
    load_bus(s);
    req_i = 1'b1;
    step(2);
    chk("R1 ack low after 2", 32'(ack_o), 0);
    chk("R8 ready held", 32'(frame_ready_o), 32'(ready_before));
    step(1);
    chk("R1 ack low after 3", 32'(ack_o), 0);
    chk("R8 ready low on new req", 32'(frame_ready_o), 0);
    step(1);
    chk("R1 ack high after 4", 32'(ack_o), 1);
    chk("R8 ready after capture", 32'(frame_ready_o), 1);
    req_i = 1'b0;
    step(2);
    chk("R3 ack still high", 32'(ack_o), 1);
    step(1);
    chk("R3 ack low after 3", 32'(ack_o), 0);
    chk("R8 ready stays", 32'(frame_ready_o), 1);
  endtask

  task automatic t_readout(int s);
    read_word(0, 0, s, "R2 R5 word0 real");
    read_word(0, 1, s, "R5 word1 imag");
    read_word(13, 1, s, "R5 pt13 imag");
    read_word(31, 0, s, "R5 pt31 real");
    read_word(31, 1, s, "R2 R5 last word");
    read_word(22, 0, s, "R6 next-edge update");
  endtask

  task automatic t_hold_req(int old_s, int new_s);
    load_bus(new_s);
    req_i = 1'b1;
    step(4);
    load_bus(new_s + 1);
    step(10);
    chk("R4 ack held", 32'(ack_o), 1);
    req_i = 1'b0;
    step(3);
    chk("R4 ack returned low", 32'(ack_o), 0);
    read_word(5, 0, new_s, "R4 first bus kept");
    read_word(9, 1, new_s, "R4 no recapture");
    t_transfer(old_s, 1'b1);
    read_word(9, 1, old_s, "R4 new transfer after low");
  endtask

  task automatic t_disable(int s);
    logic [WW-1:0] held;
    held = rd_word_o;
    en_i = 1'b0;
    load_bus(s);
    req_i = 1'b1;
    pt_sel_i = 5'd3; part_sel_i = 1'b0;
    step(8);
    chk("R7 no ack while off", 32'(ack_o), 0);
    chk("R7 ready held", 32'(frame_ready_o), 1);
    chk("R7 read frozen", 32'(rd_word_o), 32'(held));
    en_i = 1'b1;
    step(1);
    chk("R7 load after enable", 32'(ack_o), 0);
    step(1);
    chk("R7 ack after enable", 32'(ack_o), 1);
    req_i = 1'b0;
    step(3);
    chk("R3 ack low", 32'(ack_o), 0);
    read_word(3, 0, s, "R7 capture after enable");
  endtask

  initial begin
    rst_ni = 1'b0; en_i = 1'b1; req_i = 1'b0; frame_i = '0;
    pt_sel_i = '0; part_sel_i = 1'b0;
    step(3);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_transfer(1, 1'b0);
    t_readout(1);
    t_transfer(2, 1'b1);
    t_readout(2);
    t_hold_req(4, 6);
    t_disable(9);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule